// File: doc/BRIEF.md
# Completion-Time Physical Register Allocator

This unit renames the destination of each in-order dispatched instruction to a virtual tag and delays physical register binding until the instruction completes. The virtual tag is the reorder slot the instruction occupies, so the tag also gives the instruction's age. At rename, the logical-to-virtual map is updated and no physical register is consumed. At completion, the unit tries to bind a physical register to that tag. A completion that is denied must execute again and request again.

Two policies keep the machine from locking up when registers run short, and `steal_mode_i` picks one. In reserve mode, the last free register is held for the oldest in-flight instruction. In steal mode there is no reserve, and a requester that finds nothing free takes the register of the youngest already-bound instruction that is younger than itself. That victim loses its binding and must execute again. At commit, the register of the previous committed mapping of the committing logical destination is released, and a completion in the same cycle can use it. The reorder depth must be a power of two, and the physical count must be at least the logical count plus one.

Top module: `vp_rename_alloc`

## Requirements
- R1: After reset, logical register i is committed to physical register i, physical registers NUM_LREGS..NUM_PREGS-1 are free, the window is empty, `ren_ready_o` is 1, `ren_vtag_o` is 0, `cmt_ready_o` is 0, no tag is bound, and no logical register has a pending producer.
- R2: An accepted rename returns `ren_vtag_o` equal to the current tail slot, and the tail advances by one modulo ROB_DEPTH. In the same cycle, `ren_prev_vtag_o`/`ren_prev_pend_o` give the earlier in-flight producer of that logical register. Rename consumes no physical register.
- R3: A granted completion that takes a free register receives the lowest-numbered free physical register on `cmp_preg_o`. From the next cycle, a lookup of that tag reports bound with that register.
- R4: In reserve mode (`steal_mode_i`=0), a completion from any instruction other than the oldest is denied when fewer than two registers are free, and it never steals.
- R5: A completion from the oldest in-flight instruction is always granted in either mode. It takes a free register when one exists and otherwise steals.
- R6: `cmt_ready_o` rises only when the head slot is bound. A commit releases the committed register of the head's logical destination, shows it on `cmt_freed_preg_o`, and makes it available to a completion in the same cycle.
- R7: In steal mode, with a register free, any requester is granted it. With none free, the requester takes the register of the youngest bound instruction that is younger than itself. `steal_valid_o`/`steal_vtag_o` name that victim, and the victim reads unbound from the next cycle.
- R8: In steal mode, a non-oldest completion that finds no free register and no younger bound instruction is denied, and `steal_valid_o` stays 0.
- R9: When ROB_DEPTH instructions are in flight, `ren_ready_o` is 0 and a rename request changes no state.
- R10: While the head slot is unbound, `cmt_ready_o` is 0 and a commit request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| steal_mode_i | input | 1 | 0 selects the reserve policy, 1 selects stealing |
| ren_valid_i | input | 1 | Rename request |
| ren_lreg_i | input | clog2(NUM_LREGS) | Logical destination to rename |
| ren_ready_o | output | 1 | Window has room for a rename |
| ren_vtag_o | output | clog2(ROB_DEPTH) | Tag given to the renamed instruction |
| ren_prev_vtag_o | output | clog2(ROB_DEPTH) | Earlier producer tag of `ren_lreg_i` |
| ren_prev_pend_o | output | 1 | Earlier producer is still in flight |
| cmp_valid_i | input | 1 | Completion request |
| cmp_vtag_i | input | clog2(ROB_DEPTH) | Tag (and age) of the completing instruction |
| cmp_grant_o | output | 1 | Request is granted a physical register |
| cmp_preg_o | output | clog2(NUM_PREGS) | Register granted |
| steal_valid_o | output | 1 | The grant is taken from a victim |
| steal_vtag_o | output | clog2(ROB_DEPTH) | Victim tag, which must execute again |
| cmt_valid_i | input | 1 | Commit request for the head |
| cmt_ready_o | output | 1 | Head is bound and may commit |
| cmt_freed_preg_o | output | clog2(NUM_PREGS) | Register released by a commit |
| lkp_vtag_i | input | clog2(ROB_DEPTH) | Tag to look up |
| lkp_bound_o | output | 1 | Tag has a physical register |
| lkp_preg_o | output | clog2(NUM_PREGS) | Physical register of the tag |

## Verification
Grant, steal, commit-ready, freed-register and rename answers are combinational on the current state, so they are due in the same cycle as the request. The bench drives each request just after a falling edge and samples these outputs a nanosecond later, before the rising edge. Bindings, victim drops, tail and map updates appear one rising edge after the request, so lookups and rename answers that depend on them are sampled after the following falling edge. Scenarios include a commit and a completion in the same cycle, denials in both modes, a steal, and a rename attempted while the window is full.

// File: rtl/vp_pkg.sv
package vp_pkg;
  localparam bit MODE_RESERVE = 1'b0;
  localparam bit MODE_STEAL   = 1'b1;

  // distance of a slot from the window head, 0 = oldest
  function automatic logic [31:0] rel_age(input logic [31:0] idx, input logic [31:0] base,
                                          input logic [31:0] depth);
    return (idx + depth - base) % depth;
  endfunction
endpackage

// File: rtl/vp_free_list.sv
module vp_free_list #(
  parameter int NUM_PREGS  = 12,
  parameter int FIRST_FREE = 8,
  localparam int PW  = $clog2(NUM_PREGS),
  localparam int FCW = $clog2(NUM_PREGS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rel_valid_i,
  input  logic [PW-1:0]  rel_idx_i,
  input  logic           take_i,
  output logic           any_o,
  output logic [PW-1:0]  pick_o,
  output logic [FCW-1:0] cnt_o
);
  logic [NUM_PREGS-1:0] mask_q, avail, take_mask;

  always_comb begin
    avail = mask_q;
    if (rel_valid_i) avail[rel_idx_i] = 1'b1;
  end

  always_comb begin
    pick_o = '0;
    for (int i = NUM_PREGS - 1; i >= 0; i--)
      if (avail[i]) pick_o = PW'(i);
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NUM_PREGS; i++) cnt_o = cnt_o + FCW'(avail[i]);
  end

  assign any_o = |avail;

  always_comb begin
    take_mask = '0;
    if (take_i) take_mask[pick_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PREGS; i++) mask_q[i] <= (i >= FIRST_FREE);
    end else begin
      mask_q <= avail & ~take_mask;
    end
  end
endmodule

// File: rtl/vp_steal_pick.sv
module vp_steal_pick #(
  parameter int ROB_DEPTH = 16,
  localparam int VW = $clog2(ROB_DEPTH)
) (
  input  logic [ROB_DEPTH-1:0] cand_i,
  input  logic [VW-1:0]        base_i,
  input  logic [VW-1:0]        req_i,
  output logic                 found_o,
  output logic [VW-1:0]        victim_o
);
  import vp_pkg::*;

  logic [31:0] req_age, best_age;

  always_comb begin
    req_age  = rel_age(32'(req_i), 32'(base_i), 32'(ROB_DEPTH));
    best_age = '0;
    found_o  = 1'b0;
    victim_o = '0;
    for (int i = 0; i < ROB_DEPTH; i++) begin
      if (cand_i[i] && rel_age(32'(i), 32'(base_i), 32'(ROB_DEPTH)) > req_age &&
          (!found_o || rel_age(32'(i), 32'(base_i), 32'(ROB_DEPTH)) > best_age)) begin
        found_o  = 1'b1;
        best_age = rel_age(32'(i), 32'(base_i), 32'(ROB_DEPTH));
        victim_o = VW'(i);
      end
    end
  end
endmodule

// File: rtl/vp_rename_alloc.sv
module vp_rename_alloc #(
  parameter int NUM_LREGS = 8,
  parameter int NUM_PREGS = 12,
  parameter int ROB_DEPTH = 16,
  localparam int LW  = $clog2(NUM_LREGS),
  localparam int PW  = $clog2(NUM_PREGS),
  localparam int VW  = $clog2(ROB_DEPTH),
  localparam int CW  = $clog2(ROB_DEPTH + 1),
  localparam int FCW = $clog2(NUM_PREGS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          steal_mode_i,
  input  logic          ren_valid_i,
  input  logic [LW-1:0] ren_lreg_i,
  output logic          ren_ready_o,
  output logic [VW-1:0] ren_vtag_o,
  output logic [VW-1:0] ren_prev_vtag_o,
  output logic          ren_prev_pend_o,
  input  logic          cmp_valid_i,
  input  logic [VW-1:0] cmp_vtag_i,
  output logic          cmp_grant_o,
  output logic [PW-1:0] cmp_preg_o,
  output logic          steal_valid_o,
  output logic [VW-1:0] steal_vtag_o,
  input  logic          cmt_valid_i,
  output logic          cmt_ready_o,
  output logic [PW-1:0] cmt_freed_preg_o,
  input  logic [VW-1:0] lkp_vtag_i,
  output logic          lkp_bound_o,
  output logic [PW-1:0] lkp_preg_o
);
  import vp_pkg::*;

  logic [ROB_DEPTH-1:0] ent_valid_q, vp_valid_q, cand;
  logic [LW-1:0]        ent_lreg_q  [ROB_DEPTH];
  logic [PW-1:0]        vp_preg_q   [ROB_DEPTH];
  logic [PW-1:0]        arch_preg_q [NUM_LREGS];
  logic [VW-1:0]        lmap_vtag_q [NUM_LREGS];
  logic [NUM_LREGS-1:0] lmap_pend_q;
  logic [VW-1:0]        head_q, tail_q, eff_head, victim;
  logic [CW-1:0]        cnt_q;

  logic          ren_fire, cmt_fire, cmp_ok, is_oldest, take_free, free_any, steal_found;
  logic [LW-1:0] cmt_lreg;
  logic [PW-1:0] rel_preg, free_pick;
  logic [FCW-1:0] free_cnt;

  assign ren_ready_o     = (cnt_q != CW'(ROB_DEPTH));
  assign ren_fire        = ren_valid_i & ren_ready_o;
  assign ren_vtag_o      = tail_q;
  assign ren_prev_vtag_o = lmap_vtag_q[ren_lreg_i];
  assign ren_prev_pend_o = lmap_pend_q[ren_lreg_i];

  assign cmt_ready_o      = ent_valid_q[head_q] & vp_valid_q[head_q];
  assign cmt_fire         = cmt_valid_i & cmt_ready_o;
  assign cmt_lreg         = ent_lreg_q[head_q];
  assign rel_preg         = arch_preg_q[cmt_lreg];
  assign cmt_freed_preg_o = rel_preg;

  // age is judged against the head as it stands after this cycle's commit
  assign eff_head  = head_q + VW'(cmt_fire);
  assign is_oldest = (cmp_vtag_i == eff_head);
  assign cmp_ok    = cmp_valid_i & ent_valid_q[cmp_vtag_i] & ~vp_valid_q[cmp_vtag_i];

  assign lkp_bound_o = vp_valid_q[lkp_vtag_i];
  assign lkp_preg_o  = vp_preg_q[lkp_vtag_i];

  always_comb begin
    cand = ent_valid_q & vp_valid_q;
    if (cmt_fire) cand[head_q] = 1'b0;
  end

  vp_free_list #(.NUM_PREGS(NUM_PREGS), .FIRST_FREE(NUM_LREGS)) u_free (
    .clk_i, .rst_ni,
    .rel_valid_i(cmt_fire), .rel_idx_i(rel_preg), .take_i(take_free),
    .any_o(free_any), .pick_o(free_pick), .cnt_o(free_cnt)
  );

  vp_steal_pick #(.ROB_DEPTH(ROB_DEPTH)) u_pick (
    .cand_i(cand), .base_i(eff_head), .req_i(cmp_vtag_i),
    .found_o(steal_found), .victim_o(victim)
  );

  always_comb begin
    take_free     = 1'b0;
    cmp_grant_o   = 1'b0;
    steal_valid_o = 1'b0;
    steal_vtag_o  = victim;
    cmp_preg_o    = free_pick;
    if (cmp_ok) begin
      if (steal_mode_i == MODE_STEAL || is_oldest) begin
        if (free_any) begin
          take_free   = 1'b1;
          cmp_grant_o = 1'b1;
        end else if (steal_found) begin
          cmp_grant_o   = 1'b1;
          steal_valid_o = 1'b1;
          cmp_preg_o    = vp_preg_q[victim];
        end
      end else if (free_cnt >= FCW'(2)) begin
        take_free   = 1'b1;
        cmp_grant_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_valid_q <= '0;
      vp_valid_q  <= '0;
      lmap_pend_q <= '0;
      head_q      <= '0;
      tail_q      <= '0;
      cnt_q       <= '0;
      for (int i = 0; i < ROB_DEPTH; i++) begin
        ent_lreg_q[i] <= '0;
        vp_preg_q[i]  <= '0;
      end
      for (int l = 0; l < NUM_LREGS; l++) begin
        arch_preg_q[l] <= PW'(l);
        lmap_vtag_q[l] <= '0;
      end
    end else begin
      if (cmt_fire) begin
        ent_valid_q[head_q]   <= 1'b0;
        vp_valid_q[head_q]    <= 1'b0;
        arch_preg_q[cmt_lreg] <= vp_preg_q[head_q];
        if (lmap_vtag_q[cmt_lreg] == head_q) lmap_pend_q[cmt_lreg] <= 1'b0;
        head_q <= head_q + 1'b1;
      end
      if (ren_fire) begin
        ent_valid_q[tail_q]     <= 1'b1;
        ent_lreg_q[tail_q]      <= ren_lreg_i;
        vp_valid_q[tail_q]      <= 1'b0;
        lmap_vtag_q[ren_lreg_i] <= tail_q;
        lmap_pend_q[ren_lreg_i] <= 1'b1;
        tail_q <= tail_q + 1'b1;
      end
      if (steal_valid_o) vp_valid_q[victim] <= 1'b0;
      if (cmp_grant_o) begin
        vp_valid_q[cmp_vtag_i] <= 1'b1;
        vp_preg_q[cmp_vtag_i]  <= cmp_preg_o;
      end
      cnt_q <= cnt_q + CW'(ren_fire) - CW'(cmt_fire);
    end
  end
endmodule

// File: rtl/vp_rename_alloc_chk.sv
module vp_rename_alloc_chk #(
  parameter int NUM_LREGS = 8,
  parameter int NUM_PREGS = 12,
  parameter int ROB_DEPTH = 16,
  localparam int VW  = $clog2(ROB_DEPTH),
  localparam int FCW = $clog2(NUM_PREGS + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 steal_mode_i,
  input logic                 cmp_ok,
  input logic                 is_oldest,
  input logic                 cmp_grant_o,
  input logic                 steal_valid_o,
  input logic [VW-1:0]        steal_vtag_o,
  input logic [VW-1:0]        cmp_vtag_i,
  input logic [VW-1:0]        eff_head,
  input logic [ROB_DEPTH-1:0] vp_valid_q,
  input logic [FCW-1:0]       free_cnt
);
  AST_OLDEST_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_ok && is_oldest |-> cmp_grant_o); // R5
  AST_RESERVE_NO_STEAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !steal_mode_i && steal_valid_o |-> is_oldest); // R4
  AST_RESERVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !steal_mode_i && cmp_grant_o && !is_oldest |-> free_cnt >= FCW'(2)); // R4
  AST_STEAL_YOUNGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steal_valid_o |-> VW'(steal_vtag_o - eff_head) > VW'(cmp_vtag_i - eff_head)); // R7
  AST_STEAL_IS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steal_valid_o |-> cmp_grant_o); // R7
  AST_VICTIM_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steal_valid_o |=> !vp_valid_q[$past(steal_vtag_o)]); // R7
  AST_GRANT_BINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_grant_o |=> vp_valid_q[$past(cmp_vtag_i)]); // R3
  AST_FREE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt <= FCW'(NUM_PREGS - NUM_LREGS)); // R6
endmodule

bind vp_rename_alloc vp_rename_alloc_chk #(
  .NUM_LREGS(NUM_LREGS), .NUM_PREGS(NUM_PREGS), .ROB_DEPTH(ROB_DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .steal_mode_i(steal_mode_i), .cmp_ok(cmp_ok),
  .is_oldest(is_oldest), .cmp_grant_o(cmp_grant_o), .steal_valid_o(steal_valid_o),
  .steal_vtag_o(steal_vtag_o), .cmp_vtag_i(cmp_vtag_i), .eff_head(eff_head),
  .vp_valid_q(vp_valid_q), .free_cnt(free_cnt)
);

// File: tb/tb_vp_rename_alloc.sv
module tb_vp_rename_alloc;
  localparam int NL = 2, NP = 4, ND = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic steal_mode, ren_valid, cmp_valid, cmt_valid;
  logic [0:0] ren_lreg;
  logic [1:0] cmp_vtag, lkp_vtag;
  logic ren_ready, ren_prev_pend, cmp_grant, steal_valid, cmt_ready, lkp_bound;
  logic [1:0] ren_vtag, ren_prev_vtag, steal_vtag, cmp_preg, cmt_freed, lkp_preg;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vp_rename_alloc #(.NUM_LREGS(NL), .NUM_PREGS(NP), .ROB_DEPTH(ND)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .steal_mode_i(steal_mode),
    .ren_valid_i(ren_valid), .ren_lreg_i(ren_lreg), .ren_ready_o(ren_ready),
    .ren_vtag_o(ren_vtag), .ren_prev_vtag_o(ren_prev_vtag), .ren_prev_pend_o(ren_prev_pend),
    .cmp_valid_i(cmp_valid), .cmp_vtag_i(cmp_vtag), .cmp_grant_o(cmp_grant),
    .cmp_preg_o(cmp_preg), .steal_valid_o(steal_valid), .steal_vtag_o(steal_vtag),
    .cmt_valid_i(cmt_valid), .cmt_ready_o(cmt_ready), .cmt_freed_preg_o(cmt_freed),
    .lkp_vtag_i(lkp_vtag), .lkp_bound_o(lkp_bound), .lkp_preg_o(lkp_preg)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = 1'b0; cmp_valid = 1'b0; cmt_valid = 1'b0;
  endtask

  task automatic next();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); steal_mode = 1'b0; ren_lreg = '0; cmp_vtag = '0; lkp_vtag = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    next(); #1;
    chk("R1 ren_ready", int'(ren_ready), 1);
    chk("R1 ren_vtag", int'(ren_vtag), 0);
    chk("R1 cmt_ready", int'(cmt_ready), 0);
    chk("R1 lkp_bound", int'(lkp_bound), 0);
    chk("R1 prev_pend", int'(ren_prev_pend), 0);
    // fill window: l0,l1,l0,l1
    next(); ren_valid = 1; ren_lreg = 0; #1;
    chk("R2 vtag", int'(ren_vtag), 0); chk("R2 pend", int'(ren_prev_pend), 0);
    next(); ren_valid = 1; ren_lreg = 1; #1;
    chk("R2 vtag", int'(ren_vtag), 1); chk("R2 pend", int'(ren_prev_pend), 0);
    next(); ren_valid = 1; ren_lreg = 0; #1;
    chk("R2 vtag", int'(ren_vtag), 2); chk("R2 prev", int'(ren_prev_vtag), 0);
    chk("R2 pend", int'(ren_prev_pend), 1);
    next(); ren_valid = 1; ren_lreg = 1; #1;
    chk("R2 vtag", int'(ren_vtag), 3); chk("R2 prev", int'(ren_prev_vtag), 1);
    next(); ren_valid = 1; ren_lreg = 0; #1;
    chk("R9 full", int'(ren_ready), 0);
    // reserve mode, free {p2,p3}
    next(); cmp_valid = 1; cmp_vtag = 2; #1;
    chk("R3 grant", int'(cmp_grant), 1); chk("R3 preg", int'(cmp_preg), 2);
    chk("R3 steal", int'(steal_valid), 0);
    next(); cmp_valid = 1; cmp_vtag = 3; lkp_vtag = 2; #1;
    chk("R3 lkp_bound", int'(lkp_bound), 1); chk("R3 lkp_preg", int'(lkp_preg), 2);
    chk("R4 deny", int'(cmp_grant), 0); chk("R4 steal", int'(steal_valid), 0);
    next(); cmp_valid = 1; cmp_vtag = 1; cmt_valid = 1; #1;
    chk("R4 deny", int'(cmp_grant), 0); chk("R10 cmt_ready", int'(cmt_ready), 0);
    next(); cmp_valid = 1; cmp_vtag = 0; #1;
    chk("R5 grant", int'(cmp_grant), 1); chk("R5 preg", int'(cmp_preg), 3);
    // commit head0 and complete vtag1 in the same cycle
    next(); cmt_valid = 1; cmp_valid = 1; cmp_vtag = 1; #1;
    chk("R6 cmt_ready", int'(cmt_ready), 1); chk("R6 freed", int'(cmt_freed), 0);
    chk("R6 grant", int'(cmp_grant), 1); chk("R6 preg", int'(cmp_preg), 0);
    next(); ren_valid = 1; ren_lreg = 0; #1;
    chk("R9 ready", int'(ren_ready), 1); chk("R9 vtag", int'(ren_vtag), 0);
    chk("R9 prev", int'(ren_prev_vtag), 2); chk("R9 pend", int'(ren_prev_pend), 1);
    // steal mode
    next(); steal_mode = 1; cmp_valid = 1; cmp_vtag = 3; #1;
    chk("R8 deny", int'(cmp_grant), 0); chk("R8 steal", int'(steal_valid), 0);
    next(); cmt_valid = 1; #1;
    chk("R6 freed", int'(cmt_freed), 1);
    next(); cmp_valid = 1; cmp_vtag = 0; #1;
    chk("R7 free grant", int'(cmp_grant), 1); chk("R7 free preg", int'(cmp_preg), 1);
    next(); cmp_valid = 1; cmp_vtag = 3; #1;
    chk("R7 grant", int'(cmp_grant), 1); chk("R7 preg", int'(cmp_preg), 1);
    chk("R7 steal", int'(steal_valid), 1); chk("R7 victim", int'(steal_vtag), 0);
    next(); lkp_vtag = 0; #1;
    chk("R7 victim unbound", int'(lkp_bound), 0);
    lkp_vtag = 3; #1;
    chk("R7 thief bound", int'(lkp_bound), 1); chk("R7 thief preg", int'(lkp_preg), 1);
    next(); cmt_valid = 1; #1;
    chk("R6 freed", int'(cmt_freed), 3);
    next(); cmt_valid = 1; #1;
    chk("R6 freed", int'(cmt_freed), 0);
    next(); cmp_valid = 1; cmp_vtag = 0; #1;
    chk("R5 grant", int'(cmp_grant), 1); chk("R5 preg", int'(cmp_preg), 0);
    chk("R5 steal", int'(steal_valid), 0);
    next();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule